// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes a condition code, the five arithmetic status flags (zero, carry, overflow, sign, parity) and the current value of a loop count register. From these it forms one taken/not-taken bit. The decode stage presents a request with `in_valid`, and the decision appears on registered outputs one clock later. Fetch and target address generation use that bit.

The condition codes come in pairs. An even code selects a base predicate, and the next odd code selects its negation. Mnemonics that name the same test, such as "equal" and "zero" or "below" and "carry", share one code. Four groups of tests are covered:

- single-flag tests;
- unsigned ordering built from carry and zero;
- signed ordering built from sign, overflow and zero;
- a count-is-zero test that looks at no flag.

Top module: `branch_cond_eval`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` and `out_taken` are 0 after that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge, and `out_taken` is the decision for the inputs sampled at that edge (one cycle of latency).
- R3: Code 4 (equal/zero) is taken when zf=1. Code 5 (not equal/not zero) is taken when zf=0.
- R4: Unsigned tests. Code 2 (below/carry) is taken when cf=1. Code 3 (above-or-equal/no carry) is taken when cf=0. Code 6 (below-or-equal) is taken when cf=1 or zf=1. Code 7 (above) is taken when cf=0 and zf=0.
- R5: Signed tests. Code 12 (less) is taken when sf differs from of. Code 13 (greater-or-equal) is taken when sf equals of. Code 14 (less-or-equal) is taken when zf=1 or sf differs from of. Code 15 (greater) is taken when zf=0 and sf equals of.
- R6: Code 0 is taken when of=1 and code 1 when of=0. Code 8 (negative) is taken when sf=1 and code 9 when sf=0.
- R7: Code 10 (parity even) is taken when pf=1. Code 11 (parity odd) is taken when pf=0.
- R8: Code 16 is taken exactly when `count` is zero, whatever the flags are.
- R9: Codes 17 to 31 are undefined and are never taken.
- R10: `out_taken` is 0 whenever `out_valid` is 0.
- R11: For every flag setting, odd code 2k+1 (k = 0..7) gives the opposite decision to even code 2k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for this cycle |
| cond_code | input | 5 | Condition selector |
| flag_zf | input | 1 | Zero flag |
| flag_cf | input | 1 | Carry flag |
| flag_of | input | 1 | Overflow flag |
| flag_sf | input | 1 | Sign flag |
| flag_pf | input | 1 | Parity flag |
| count | input | CNT_W | Loop count register value |
| out_valid | output | 1 | Decision valid, one cycle after the request |
| out_taken | output | 1 | Branch taken |

## Verification
The assertions assume that the inputs hold stable values at each rising edge and that a request is not checked in the cycle just after a reset. The bench meets both conditions. It drives every input on the falling edge, keeps reset high from time zero, and releases reset a full cycle before the first request. The sweep covers all 32 codes against all 32 flag combinations, and each pairing is run with a zero, a one and an all-ones count.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int CODE_W   = 5;
  localparam int NUM_BASE = 8;

  typedef struct packed {
    logic zf;
    logic cf;
    logic of;
    logic sf;
    logic pf;
  } flags_t;

  // Even codes name the base predicates; code | 1 is the negation.
  typedef enum logic [CODE_W-1:0] {
    CC_OVFL  = 5'd0,
    CC_CARRY = 5'd2,
    CC_ZERO  = 5'd4,
    CC_BLEQ  = 5'd6,
    CC_SIGN  = 5'd8,
    CC_PAR   = 5'd10,
    CC_LT    = 5'd12,
    CC_LE    = 5'd14,
    CC_CNTZ  = 5'd16
  } cond_e;
endpackage

// File: rtl/bce_predicates.sv
module bce_predicates
  import bce_pkg::*;
(
  input  flags_t              flags,
  output logic [NUM_BASE-1:0] base
);
  logic sign_ne_ovf;

  always_comb begin
    sign_ne_ovf = flags.sf ^ flags.of;
    base[CC_OVFL[3:1]]  = flags.of;
    base[CC_CARRY[3:1]] = flags.cf;
    base[CC_ZERO[3:1]]  = flags.zf;
    base[CC_BLEQ[3:1]]  = flags.cf | flags.zf;
    base[CC_SIGN[3:1]]  = flags.sf;
    base[CC_PAR[3:1]]   = flags.pf;
    base[CC_LT[3:1]]    = sign_ne_ovf;
    base[CC_LE[3:1]]    = flags.zf | sign_ne_ovf;
  end
endmodule

// File: rtl/bce_count_zero.sv
module bce_count_zero #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  output logic             is_zero
);
  assign is_zero = ~|count;
endmodule

// File: rtl/bce_select.sv
module bce_select
  import bce_pkg::*;
(
  input  logic [CODE_W-1:0]   code,
  input  logic [NUM_BASE-1:0] base,
  input  logic                cnt_zero,
  output logic                taken
);
  localparam int SEL_W = $clog2(NUM_BASE);

  logic [SEL_W-1:0] sel;

  always_comb begin
    sel = code[SEL_W:1];
    if (code[CODE_W-1]) begin
      // upper half: only the count test is defined
      taken = (code[CODE_W-2:0] == '0) && cnt_zero;
    end else begin
      taken = base[sel] ^ code[0];
    end
  end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [CODE_W-1:0]   cond_code,
  input  logic                flag_zf,
  input  logic                flag_cf,
  input  logic                flag_of,
  input  logic                flag_sf,
  input  logic                flag_pf,
  input  logic [CNT_W-1:0]    count,
  output logic                out_valid,
  output logic                out_taken
);
  flags_t              flags;
  logic [NUM_BASE-1:0] base;
  logic                cnt_zero;
  logic                taken_d;

  assign flags = '{zf: flag_zf, cf: flag_cf, of: flag_of, sf: flag_sf, pf: flag_pf};

  bce_predicates u_pred (
    .flags (flags),
    .base  (base)
  );

  bce_count_zero #(.CNT_W(CNT_W)) u_cz (
    .count   (count),
    .is_zero (cnt_zero)
  );

  bce_select u_sel (
    .code     (cond_code),
    .base     (base),
    .cnt_zero (cnt_zero),
    .taken    (taken_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_taken <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_taken <= in_valid & taken_d;
    end
  end

  // Checks on the registered decision against the sampled inputs
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> (out_valid == $past(in_valid)));

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !out_taken);

  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(cond_code) == 5'd4) |-> (out_taken == $past(flag_zf)));

  assert_greater_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(cond_code) == 5'd15)
      |-> (out_taken == (!$past(flag_zf) && ($past(flag_sf) == $past(flag_of)))));

  assert_above_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(cond_code) == 5'd7)
      |-> (out_taken == (!$past(flag_cf) && !$past(flag_zf))));

  assert_cntz_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && $past(cond_code) == 5'd16)
      |-> (out_taken == ($past(count) == '0)));

  assert_undef_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cond_code) > 5'd16) |-> !out_taken);
endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [4:0]       cond_code = '0;
  logic             zf = 0, cf = 0, of = 0, sf = 0, pf = 0;
  logic [CNT_W-1:0] count = '0;
  logic             out_valid, out_taken;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  branch_cond_eval #(.CNT_W(CNT_W)) i_branch_cond_eval (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_code(cond_code),
    .flag_zf(zf), .flag_cf(cf), .flag_of(of), .flag_sf(sf), .flag_pf(pf),
    .count(count), .out_valid(out_valid), .out_taken(out_taken)
  );

  function automatic bit expect_taken(input int c, input bit z, input bit ca,
                                      input bit o, input bit s, input bit p,
                                      input int unsigned cn);
    bit b;
    if (c == 16) return (cn == 0);
    if (c > 16) return 0;
    case (c / 2)
      0: b = o;
      1: b = ca;
      2: b = z;
      3: b = ca || z;
      4: b = s;
      5: b = p;
      6: b = (s != o);
      default: b = z || (s != o);
    endcase
    return (c % 2 == 1) ? !b : b;
  endfunction

  function automatic string req_of(input int c);
    if (c > 16) return "R9";
    if (c == 16) return "R8";
    case (c)
      4, 5: return "R3";
      2, 3, 6, 7: return "R4";
      12, 13, 14, 15: return "R5";
      0, 1, 8, 9: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", out_valid, 1'b0, "out_valid in reset");
    check("R1", out_taken, 1'b0, "out_taken in reset");
    rst = 1'b0;
    @(negedge clk);

    // R10: idle request with a condition that would be taken
    in_valid = 0; cond_code = 5'd4; zf = 1;
    @(negedge clk);
    check("R10", out_taken, 1'b0, "taken while idle");
    check("R2", out_valid, 1'b0, "valid while idle");

    // Exhaustive sweep: codes x flags x count values
    for (int ci = 0; ci < 3; ci++) begin
      for (int c = 0; c < 32; c++) begin
        for (int f = 0; f < 32; f++) begin
          int unsigned cn;
          bit e;
          cn = (ci == 0) ? 0 : (ci == 1) ? 1 : (1 << CNT_W) - 1;
          in_valid = 1; cond_code = c[4:0];
          zf = f[0]; cf = f[1]; of = f[2]; sf = f[3]; pf = f[4];
          count = cn[CNT_W-1:0];
          e = expect_taken(c, f[0], f[1], f[2], f[3], f[4], cn);
          @(negedge clk);
          check("R2", out_valid, 1'b1, "valid after request");
          check(req_of(c), out_taken, e,
                $sformatf("code=%0d flags=%05b count=%0d", c, f[4:0], cn));
        end
      end
    end

    // R11: paired codes give opposite decisions
    for (int k = 0; k < 8; k++) begin
      for (int f = 0; f < 32; f++) begin
        bit even_t;
        in_valid = 1; cond_code = 5'(2 * k);
        zf = f[0]; cf = f[1]; of = f[2]; sf = f[3]; pf = f[4];
        @(negedge clk);
        even_t = out_taken;
        cond_code = 5'(2 * k + 1);
        @(negedge clk);
        check("R11", out_taken, !even_t, $sformatf("pair k=%0d flags=%05b", k, f[4:0]));
      end
    end

    // R1: reset in mid-stream clears the outputs
    in_valid = 1; cond_code = 5'd4; zf = 1; rst = 1;
    @(negedge clk);
    check("R1", out_valid, 1'b0, "valid after mid reset");
    check("R1", out_taken, 1'b0, "taken after mid reset");
    rst = 0; in_valid = 0;
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule